// File: doc/BRIEF.md
# Channel Status LED Sequencer

This block drives one status LED from the state of a four-channel stopwatch. It shows which channels are still counting without needing a display. While initialization is in progress the LED stays lit. Once every channel has been stopped it stays dark. While timing runs, it plays a repeating frame of eight decisecond slots. The first four slots stand for channels 1 to 4, and each is lit only while its channel is still counting. The last four slots are always dark, so that the viewer can tell where a frame begins.

A decisecond tick from the timebase moves the frame forward. The run flag and the four per-channel stopped flags come from the stopwatch control. Each start of timing begins a new frame at channel 1. When the clock is paused with channels still open, the LED keeps its last level until something changes. The LED bit comes straight from a register, so it carries no combinational glitches.

Top module: `chan_led_seq`

## Requirements
- R1: During reset and in the first cycle after reset is released, with no other input active, the LED output is low and the slot counter is at slot 0.
- R2: In the cycle after `init_i` is sampled high, the LED is high, whatever the values of `run_i`, `tick_i` and `stopped_i`. Init has the highest priority.
- R3: In the cycle after a sample with `init_i` low and all four `stopped_i` bits high, the LED is low, whatever the value of `run_i`.
- R4: A rising edge of `run_i` (sampled high after being sampled low) resets the slot counter to slot 0, with `init_i` low and not all channels stopped. In the following cycle the LED is high if and only if `stopped_i[0]` is low.
- R5: While timing runs, each sampled `tick_i` advances the slot by one, and slot 7 wraps to slot 0. Cycles without a tick leave the slot unchanged.
- R6: In slots 0 to 3, the LED is high if and only if the stopped bit of that channel is low. Bit k of `stopped_i` belongs to channel k+1 and is shown in slot k.
- R7: In slots 4 to 7 the LED is low while timing runs.
- R8: If a stopped bit changes during its own slot, the LED follows the change in the next cycle, without waiting for a tick.
- R9: When `init_i` and `run_i` are low and not all channels are stopped, the LED holds its level, and ticks have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle decisecond pulse |
| init_i | input | 1 | Initialization in progress |
| run_i | input | 1 | Timing is active |
| stopped_i | input | NUM_CH (4) | Per-channel stopped flags, bit k is channel k+1 |
| led_o | output | 1 | LED drive, high is lit |

## Verification
The hardest case to reach is a pause that falls at a chosen point in the frame. The LED must then keep a lit level from a channel slot or a dark level from the gap. It must also stay frozen through ticks, and a later restart must still begin at channel 1. The stimulus reaches this state by counting ticks from a fresh start to stop at slot 2, and in a second pass at slot 5. It then drops the run flag, sends ticks into the pause, and raises the run flag again. The other hard case is a channel that stops or reopens in the middle of its own slot. The bench times that flag change between two ticks.

// File: rtl/chan_led_seq_pkg.sv
package chan_led_seq_pkg;

    // Operating mode chosen from the control inputs, highest priority first.
    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_DONE = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_HOLD = 2'd3
    } led_mode_e;

endpackage

// File: rtl/chan_led_mode_sel.sv
module chan_led_mode_sel
    import chan_led_seq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              init_i,
    input  logic              run_i,
    input  logic [NUM_CH-1:0] stopped_i,
    output led_mode_e         mode_o
);

    logic all_done;

    assign all_done = &stopped_i;

    // Init wins over everything, then all-stopped, then the run flag.
    always_comb begin
        if (init_i) begin
            mode_o = MODE_INIT;
        end else if (all_done) begin
            mode_o = MODE_DONE;
        end else if (run_i) begin
            mode_o = MODE_RUN;
        end else begin
            mode_o = MODE_HOLD;
        end
    end

endmodule

// File: rtl/chan_led_slot_ctr.sv
module chan_led_slot_ctr #(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              adv_i,
    output logic [SLOT_W-1:0] slot_d_o,
    output logic [SLOT_W-1:0] slot_q_o
);

    logic [SLOT_W-1:0] slot_d;
    logic [SLOT_W-1:0] slot_q;

    // The frame length is a power of two, so the counter wraps by itself.
    always_comb begin
        slot_d = slot_q;
        if (clear_i) begin
            slot_d = '0;
        end else if (adv_i) begin
            slot_d = slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_d_o = slot_d;
    assign slot_q_o = slot_q;

endmodule

// File: rtl/chan_led_slot_lit.sv
module chan_led_slot_lit #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 3
) (
    input  logic [NUM_CH-1:0] stopped_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              lit_o
);

    localparam int FRAME = 1 << SLOT_W;

    logic [FRAME-1:0] lit_vec;

    // Channel slots show "still counting"; the slots after them form the dark gap.
    for (genvar g = 0; g < FRAME; g++) begin : g_slot
        if (g < NUM_CH) begin : g_chan
            assign lit_vec[g] = ~stopped_i[g];
        end else begin : g_gap
            assign lit_vec[g] = 1'b0;
        end
    end

    assign lit_o = lit_vec[slot_i];

endmodule

// File: rtl/chan_led_seq.sv
module chan_led_seq
    import chan_led_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              init_i,
    input  logic              run_i,
    input  logic [NUM_CH-1:0] stopped_i,
    output logic              led_o
);

    typedef struct packed {
        logic led;
        logic run;
    } seq_state_t;

    seq_state_t        st_d;
    seq_state_t        st_q;
    led_mode_e         mode;
    logic              start;
    logic              slot_clear;
    logic              slot_adv;
    logic              lit;
    logic              run_q;
    logic [SLOT_W-1:0] slot_d;
    logic [SLOT_W-1:0] slot_q;

    assign run_q = st_q.run;
    assign start = run_i & ~st_q.run;

    chan_led_mode_sel #(
        .NUM_CH (NUM_CH)
    ) u_mode (
        .init_i    (init_i),
        .run_i     (run_i),
        .stopped_i (stopped_i),
        .mode_o    (mode)
    );

    // Init and done park the counter at 0; a new start restarts the frame;
    // a pause freezes it.
    always_comb begin
        slot_clear = 1'b0;
        slot_adv   = 1'b0;
        case (mode)
            MODE_INIT, MODE_DONE: slot_clear = 1'b1;
            MODE_RUN: begin
                slot_clear = start;
                slot_adv   = tick_i;
            end
            default: ;
        endcase
    end

    chan_led_slot_ctr #(
        .SLOT_W (SLOT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (slot_clear),
        .adv_i    (slot_adv),
        .slot_d_o (slot_d),
        .slot_q_o (slot_q)
    );

    chan_led_slot_lit #(
        .NUM_CH (NUM_CH),
        .SLOT_W (SLOT_W)
    ) u_lit (
        .stopped_i (stopped_i),
        .slot_i    (slot_d),
        .lit_o     (lit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.run = run_i;
        case (mode)
            MODE_INIT: st_d.led = 1'b1;
            MODE_DONE: st_d.led = 1'b0;
            MODE_RUN:  st_d.led = lit;
            default:   st_d.led = st_q.led;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_o = st_q.led;

endmodule

// File: rtl/chan_led_seq_chk.sv
module chan_led_seq_chk #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              init_i,
    input logic              run_i,
    input logic [NUM_CH-1:0] stopped_i,
    input logic              led_o,
    input logic              run_q,
    input logic [SLOT_W-1:0] slot_q
);

    localparam logic [SLOT_W-1:0] CH_LIM = SLOT_W'(NUM_CH);

    // R2: init forces the LED on
    a_r2_init_on: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> led_o);

    // R3: all channels stopped forces the LED off
    a_r3_done_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && (&stopped_i)) |=> !led_o);

    // R4: a run start begins the frame at slot 0
    a_r4_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !(&stopped_i) && run_i && !run_q) |=> (slot_q == '0));

    // R5: a tick while running advances the slot by one
    a_r5_tick_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !(&stopped_i) && run_i && run_q && tick_i)
        |=> (slot_q == $past(slot_q) + 1'b1));

    // R7: gap slots are dark while running
    a_r7_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !(&stopped_i) && run_i) |=> (slot_q < CH_LIM || !led_o));

    // R9: a pause holds the LED level
    a_r9_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !run_i && !(&stopped_i)) |=> $stable(led_o));

endmodule

bind chan_led_seq chan_led_seq_chk #(
    .NUM_CH (NUM_CH),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .init_i    (init_i),
    .run_i     (run_i),
    .stopped_i (stopped_i),
    .led_o     (led_o),
    .run_q     (run_q),
    .slot_q    (slot_q)
);

// File: tb/chan_led_seq_bench.sv
module chan_led_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       init_i = 1'b0;
    logic       run_i = 1'b0;
    logic [3:0] stopped_i = 4'b0000;
    logic       led_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    chan_led_seq u_chan_led_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .init_i    (init_i),
        .run_i     (run_i),
        .stopped_i (stopped_i),
        .led_o     (led_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: led=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_lit(input int s, input logic [3:0] st);
        return (s < 4) ? ~st[s] : 1'b0;
    endfunction

    task automatic pulse_tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        step();
        check("R1", led_o, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1", led_o, 1'b0);
    endtask

    // R2 / R3: priority of init and of all-stopped
    task automatic t_init_done();
        init_i = 1'b1; run_i = 1'b1; stopped_i = 4'b1111; tick_i = 1'b1;
        step();
        check("R2", led_o, 1'b1);
        tick_i = 1'b0; init_i = 1'b0;
        step();
        check("R3", led_o, 1'b0);
        run_i = 1'b0;
        step();
        check("R3", led_o, 1'b0);
        init_i = 1'b1;
        step();
        check("R2", led_o, 1'b1);
        init_i = 1'b0;
    endtask

    // R4..R7: full frames for one channel pattern
    task automatic t_frame(input logic [3:0] pat);
        run_i = 1'b0; stopped_i = pat;
        step();
        run_i = 1'b1;
        step();
        check("R4", led_o, exp_lit(0, pat));
        for (int i = 1; i <= 17; i++) begin
            pulse_tick();
            check(((i % 8) < 4) ? "R6" : "R7", led_o, exp_lit(i % 8, pat));
            step();
            check("R5", led_o, exp_lit(i % 8, pat));
        end
        run_i = 1'b0;
        step();
    endtask

    // R9: pause keeps the level, ticks ignored; R4 restart at channel 1
    task automatic t_pause();
        stopped_i = 4'b0000; run_i = 1'b0;
        step();
        run_i = 1'b1;
        step();
        pulse_tick();
        pulse_tick();
        check("R6", led_o, 1'b1);
        run_i = 1'b0;
        step();
        check("R9", led_o, 1'b1);
        for (int i = 0; i < 5; i++) pulse_tick();
        check("R9", led_o, 1'b1);
        run_i = 1'b1;
        step();
        for (int i = 0; i < 5; i++) pulse_tick();
        check("R7", led_o, 1'b0);
        run_i = 1'b0;
        step();
        for (int i = 0; i < 3; i++) pulse_tick();
        check("R9", led_o, 1'b0);
        stopped_i = 4'b0110;
        step();
        check("R9", led_o, 1'b0);
        stopped_i = 4'b0000;
        run_i = 1'b1;
        step();
        check("R4", led_o, 1'b1);
        pulse_tick();
        check("R5", led_o, 1'b1);
        run_i = 1'b0;
        step();
    endtask

    // R8: a channel stops or reopens within its own slot; R3 when all stop
    task automatic t_midslot();
        stopped_i = 4'b0000; run_i = 1'b1;
        step();
        pulse_tick();
        check("R6", led_o, 1'b1);
        stopped_i = 4'b0010;
        step();
        check("R8", led_o, 1'b0);
        stopped_i = 4'b0000;
        step();
        check("R8", led_o, 1'b1);
        stopped_i = 4'b1111;
        step();
        check("R3", led_o, 1'b0);
        run_i = 1'b0; stopped_i = 4'b0000;
        step();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_init_done();
        t_frame(4'b0000);
        t_frame(4'b0101);
        t_frame(4'b0111);
        t_frame(4'b1000);
        t_pause();
        t_midslot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule